// File: doc/BRIEF.md
# Dual-View Sector-Protected Memory Controller

This block owns a user memory of 64 sectors, each 1024 bits, and lets two clients reach it through two different views. The block view moves whole aligned 32-bit words: a sector is 32 such blocks. The byte view moves single bytes: a sector is 128 bytes. Both views name the same storage. Byte `k` of block `b` in sector `s` is byte address `s*128 + b*4 + k`, and it sits in bits `8k+7:8k` of the block word, which makes the word little-endian.

Each sector carries two independent protection settings. A 5-bit security status controls the block view. A single write-lock bit controls the byte view. A separate configuration write port loads both settings for one sector at a time. Every request is answered with a response one cycle later, and that response carries an error flag when the request was refused.

Requests use valid/ready. A request is accepted on a rising edge where both valid and ready are high. The block view is always ready. The byte view drops ready whenever a block request is valid in the same cycle, so the byte client must hold its request stable until ready returns. Responses cannot be back-pressured: they appear for exactly one cycle, one cycle after acceptance.

Top module: `dual_view_mem`

## Requirements
- R1: A block read is answered one cycle after acceptance with `blk_rsp_valid` high and the full 32-bit word. Byte k of the block is in bits 8k+7:8k.
- R2: An allowed block write replaces all 32 bits of the addressed word. Its response has `blk_err` low and `blk_rdata` zero.
- R3: The status field decodes as follows. Bit 0 set turns protection on. With protection on, bits 2:1 = 00 deny writes, 01 deny reads and writes, and 10 or 11 allow everything. Bits 4:3 never change any outcome.
- R4: A denied block write leaves the memory unchanged and answers with `blk_err` high for one cycle.
- R5: A denied block read answers with `blk_rdata` equal to zero and `blk_err` high.
- R6: The byte port reads or writes one byte at byte address `byt_addr`, where the sector is `byt_addr[12:7]`. A byte write changes no other byte. Byte reads are never refused.
- R7: When a sector's write lock is set, every byte write into that sector is refused with `byt_err` high and the memory is unchanged. The lock has no effect on the block port, and the security status has no effect on the byte port.
- R8: A byte request with `byt_e2` = 1 is accepted but does not reach user memory. It produces no response and changes nothing.
- R9: When both ports present a request in the same cycle, the block request is served. `byt_req_ready` is low in that cycle, and the byte request is served in the first cycle without a block request.
- R10: After reset all sectors are unprotected and unlocked, no response is valid, and `byt_req_ready` is high. A configuration write sets a sector's status and lock, and these take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sector | input | 6 | Sector being configured |
| cfg_status | input | 5 | New security status for the block view |
| cfg_lock | input | 1 | New write-lock bit for the byte view |
| blk_req_valid | input | 1 | Block request valid |
| blk_req_ready | output | 1 | Block request ready (always high) |
| blk_we | input | 1 | Block request is a write |
| blk_addr | input | 11 | Block address: sector in [10:5], block in [4:0] |
| blk_wdata | input | 32 | Block write data |
| blk_rsp_valid | output | 1 | Block response valid |
| blk_rdata | output | 32 | Block read data (zero on write or denial) |
| blk_err | output | 1 | Block request refused |
| byt_req_valid | input | 1 | Byte request valid |
| byt_req_ready | output | 1 | Byte request ready |
| byt_we | input | 1 | Byte request is a write |
| byt_e2 | input | 1 | Chip-enable select bit; must be 0 to reach user memory |
| byt_addr | input | 13 | Byte address: sector in [12:7], offset in [6:0] |
| byt_wdata | input | 8 | Byte write data |
| byt_rsp_valid | output | 1 | Byte response valid |
| byt_rdata | output | 8 | Byte read data (zero on write) |
| byt_err | output | 1 | Byte request refused |

## Verification
The hardest case to observe is a refused block write into a sector whose block reads are also refused. The block port cannot show that the word stayed intact. The bench reads the same bytes back through the byte port, which that status does not affect. At the end it opens every sector and reads the whole array back against its model. It also drives both request ports on the same falling edge, so that the collision, the held-low byte ready and the deferred byte service all happen together.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  localparam int BLK_PER_SEC  = 32;
  localparam int BYTE_PER_BLK = 4;
  localparam int BYTE_PER_SEC = BLK_PER_SEC * BYTE_PER_BLK;

  typedef struct packed {
    logic [1:0] key_idx;  // kept only, never consulted
    logic [1:0] mode;
    logic       en;
  } sec_status_t;

  function automatic logic blk_write_denied(input sec_status_t s);
    return s.en && (s.mode == 2'b00 || s.mode == 2'b01);
  endfunction

  function automatic logic blk_read_denied(input sec_status_t s);
    return s.en && (s.mode == 2'b01);
  endfunction
endpackage

// File: rtl/dvm_prot_regs.sv
module dvm_prot_regs
  import dvm_pkg::*;
#(
  parameter int SECTOR_CNT = 64,
  localparam int SEC_W = $clog2(SECTOR_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEC_W-1:0] cfg_sector,
  input  sec_status_t      cfg_status,
  input  logic             cfg_lock,
  input  logic [SEC_W-1:0] blk_sec,
  output sec_status_t      blk_status,
  input  logic [SEC_W-1:0] byt_sec,
  output logic             byt_lock
);
  sec_status_t status_q [SECTOR_CNT];
  logic        lock_q   [SECTOR_CNT];

  for (genvar g = 0; g < SECTOR_CNT; g++) begin : g_sec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status_q[g] <= '0;
        lock_q[g]   <= 1'b0;
      end else if (cfg_we && cfg_sector == SEC_W'(g)) begin
        status_q[g] <= cfg_status;
        lock_q[g]   <= cfg_lock;
      end
    end
  end

  assign blk_status = status_q[blk_sec];
  assign byt_lock   = lock_q[byt_sec];

  // R10: a configuration write is visible on the lookup the next cycle
  a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sector == blk_sec && cfg_sector == byt_sec) |=>
      (($past(cfg_sector) != blk_sec) || (blk_status == $past(cfg_status))));
endmodule

// File: rtl/dvm_word_array.sv
module dvm_word_array #(
  parameter int WORDS = 2048,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic          rd_en,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (be[k]) mem[addr][k*8 +: 8] <= wdata[k*8 +: 8];
    end
    if (rd_en) rdata <= mem[addr];
  end

  // R6: a read cycle never carries write enables
  a_r6_rd_wr_exclusive: assert property (@(posedge clk) !(rd_en && (be != 4'h0)));
endmodule

// File: rtl/dvm_rsp_stage.sv
module dvm_rsp_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       deny,
  input  logic       pass,
  input  logic [1:0] lane,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic       rsp_pass,
  output logic [1:0] rsp_lane
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_pass  <= 1'b0;
      rsp_lane  <= 2'd0;
    end else begin
      rsp_valid <= fire;
      rsp_err   <= fire && deny;
      rsp_pass  <= fire && pass && !deny;
      if (fire) rsp_lane <= lane;
    end
  end

  // R4: an error is only ever flagged together with a response
  a_r4_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

// File: rtl/dual_view_mem.sv
module dual_view_mem
  import dvm_pkg::*;
#(
  parameter int SECTOR_CNT = 64,
  localparam int SEC_W = $clog2(SECTOR_CNT),
  localparam int BA_W  = SEC_W + $clog2(BLK_PER_SEC),
  localparam int YA_W  = SEC_W + $clog2(BYTE_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEC_W-1:0] cfg_sector,
  input  logic [4:0]       cfg_status,
  input  logic             cfg_lock,
  input  logic             blk_req_valid,
  output logic             blk_req_ready,
  input  logic             blk_we,
  input  logic [BA_W-1:0]  blk_addr,
  input  logic [31:0]      blk_wdata,
  output logic             blk_rsp_valid,
  output logic [31:0]      blk_rdata,
  output logic             blk_err,
  input  logic             byt_req_valid,
  output logic             byt_req_ready,
  input  logic             byt_we,
  input  logic             byt_e2,
  input  logic [YA_W-1:0]  byt_addr,
  input  logic [7:0]       byt_wdata,
  output logic             byt_rsp_valid,
  output logic [7:0]       byt_rdata,
  output logic             byt_err
);
  localparam int WORDS = SECTOR_CNT * BLK_PER_SEC;

  sec_status_t blk_st;
  logic        byt_lk;
  logic        blk_fire, byt_fire, byt_mem;
  logic        blk_wr_deny, blk_rd_deny, byt_wr_deny;
  logic [1:0]  byt_lane;
  logic [BA_W-1:0] arr_addr;
  logic [3:0]  arr_be;
  logic [31:0] arr_wdata, arr_rdata;
  logic        arr_rd;
  logic        blk_pass_q, byt_pass_q;
  logic [1:0]  blk_lane_q, byt_lane_q;

  // arbitration: block view always wins
  assign blk_req_ready = 1'b1;
  assign byt_req_ready = !blk_req_valid;
  assign blk_fire      = blk_req_valid;
  assign byt_fire      = byt_req_valid && byt_req_ready;
  assign byt_mem       = byt_fire && !byt_e2;
  assign byt_lane      = byt_addr[1:0];

  dvm_prot_regs #(.SECTOR_CNT(SECTOR_CNT)) u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sector (cfg_sector),
    .cfg_status (sec_status_t'(cfg_status)),
    .cfg_lock   (cfg_lock),
    .blk_sec    (blk_addr[BA_W-1 -: SEC_W]),
    .blk_status (blk_st),
    .byt_sec    (byt_addr[YA_W-1 -: SEC_W]),
    .byt_lock   (byt_lk)
  );

  assign blk_wr_deny = blk_we && blk_write_denied(blk_st);
  assign blk_rd_deny = !blk_we && blk_read_denied(blk_st);
  assign byt_wr_deny = byt_we && byt_lk;

  always_comb begin
    arr_addr  = blk_addr;
    arr_be    = 4'h0;
    arr_wdata = blk_wdata;
    arr_rd    = 1'b0;
    if (blk_fire) begin
      arr_be = (blk_we && !blk_wr_deny) ? 4'hF : 4'h0;
      arr_rd = !blk_we && !blk_rd_deny;
    end else if (byt_mem) begin
      arr_addr  = byt_addr[YA_W-1:2];
      arr_wdata = {4{byt_wdata}};
      arr_be    = (byt_we && !byt_wr_deny) ? (4'h1 << byt_lane) : 4'h0;
      arr_rd    = !byt_we;
    end
  end

  dvm_word_array #(.WORDS(WORDS)) u_array (
    .clk   (clk),
    .addr  (arr_addr),
    .be    (arr_be),
    .wdata (arr_wdata),
    .rd_en (arr_rd),
    .rdata (arr_rdata)
  );

  dvm_rsp_stage u_blk_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (blk_fire),
    .deny      (blk_wr_deny || blk_rd_deny),
    .pass      (!blk_we),
    .lane      (2'd0),
    .rsp_valid (blk_rsp_valid),
    .rsp_err   (blk_err),
    .rsp_pass  (blk_pass_q),
    .rsp_lane  (blk_lane_q)
  );

  dvm_rsp_stage u_byt_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (byt_mem),
    .deny      (byt_wr_deny),
    .pass      (!byt_we),
    .lane      (byt_lane),
    .rsp_valid (byt_rsp_valid),
    .rsp_err   (byt_err),
    .rsp_pass  (byt_pass_q),
    .rsp_lane  (byt_lane_q)
  );

  assign blk_rdata = blk_pass_q ? arr_rdata : 32'h0;
  assign byt_rdata = byt_pass_q ? arr_rdata[byt_lane_q*8 +: 8] : 8'h0;

  // R1: every accepted block request is answered the next cycle
  a_r1_blk_answer: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req_valid |=> blk_rsp_valid);
  // R9: the two views never answer in the same cycle
  a_r9_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_rsp_valid && byt_rsp_valid));
  // R5: a refused block read carries zero data
  a_r5_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req_valid && !blk_we) |=> (!blk_err || blk_rdata == 32'h0));
  // R7: a locked sector refuses every byte write
  a_r7_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (byt_req_valid && byt_req_ready && !byt_e2 && byt_we && byt_lk) |=> byt_err);
  // R8: a request with the select bit set is not answered
  a_r8_e2_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (byt_req_valid && byt_req_ready && byt_e2) |=> !byt_rsp_valid);
endmodule

// File: tb/test_dual_view_mem.sv
module test_dual_view_mem;
  localparam int SC = 4;
  localparam int SW = 2;
  localparam int BAW = SW + 5;
  localparam int YAW = SW + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_sector = '0;
  logic [4:0] cfg_status = '0;
  logic cfg_lock = 1'b0;
  logic blk_req_valid = 1'b0, blk_req_ready, blk_we = 1'b0;
  logic [BAW-1:0] blk_addr = '0;
  logic [31:0] blk_wdata = '0, blk_rdata;
  logic blk_rsp_valid, blk_err;
  logic byt_req_valid = 1'b0, byt_req_ready, byt_we = 1'b0, byt_e2 = 1'b0;
  logic [YAW-1:0] byt_addr = '0;
  logic [7:0] byt_wdata = '0, byt_rdata;
  logic byt_rsp_valid, byt_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [SC*128];

  always #5 clk = ~clk;

  dual_view_mem #(.SECTOR_CNT(SC)) i_dual_view_mem (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sector(cfg_sector), .cfg_status(cfg_status), .cfg_lock(cfg_lock),
    .blk_req_valid(blk_req_valid), .blk_req_ready(blk_req_ready), .blk_we(blk_we),
    .blk_addr(blk_addr), .blk_wdata(blk_wdata), .blk_rsp_valid(blk_rsp_valid),
    .blk_rdata(blk_rdata), .blk_err(blk_err),
    .byt_req_valid(byt_req_valid), .byt_req_ready(byt_req_ready), .byt_we(byt_we),
    .byt_e2(byt_e2), .byt_addr(byt_addr), .byt_wdata(byt_wdata),
    .byt_rsp_valid(byt_rsp_valid), .byt_rdata(byt_rdata), .byt_err(byt_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input int w);
    return {mdl[w*4+3], mdl[w*4+2], mdl[w*4+1], mdl[w*4]};
  endfunction

  task automatic cfg(input int s, input logic [4:0] st, input logic lk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sector = SW'(s); cfg_status = st; cfg_lock = lk;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic blk_op(input logic we, input int a, input logic [31:0] d,
                        output logic vld, output logic err, output logic [31:0] rd);
    @(negedge clk);
    blk_req_valid = 1'b1; blk_we = we; blk_addr = BAW'(a); blk_wdata = d;
    @(posedge clk); #1;
    vld = blk_rsp_valid; err = blk_err; rd = blk_rdata;
    blk_req_valid = 1'b0;
  endtask

  task automatic byt_op(input logic we, input logic e2, input int a, input logic [7:0] d,
                        output logic vld, output logic err, output logic [7:0] rd);
    @(negedge clk);
    byt_req_valid = 1'b1; byt_we = we; byt_e2 = e2; byt_addr = YAW'(a); byt_wdata = d;
    @(posedge clk); #1;
    vld = byt_rsp_valid; err = byt_err; rd = byt_rdata;
    byt_req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic v, e;
    logic [31:0] r32;
    logic [7:0] r8;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check(blk_rsp_valid == 0 && byt_rsp_valid == 0, "R10 rsp idle", {byt_rsp_valid, blk_rsp_valid}, 0);
    check(byt_req_ready == 1, "R10 ready", byt_req_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // fill all words through the open block view (R2), read back (R1)
    for (int w = 0; w < SC*32; w++) begin
      logic [31:0] d;
      d = 32'h5A3C_0000 ^ (w * 32'h0102_0305);
      blk_op(1'b1, w, d, v, e, r32);
      for (int k = 0; k < 4; k++) mdl[w*4+k] = d[k*8 +: 8];
      if (w % 16 == 0) check(v && !e && r32 == 0, "R2 open write rsp", {v, e, r32[29:0]}, 32'h8000_0000);
    end
    for (int w = 0; w < SC*32; w++) begin
      blk_op(1'b0, w, 32'h0, v, e, r32);
      check(v && !e && r32 == mword(w), "R1 readback", r32, mword(w));
    end

    // sweep every status code, lock varied independently of the code's enable
    for (int c = 0; c < 32; c++) begin
      int s, wa, ba;
      logic [4:0] st;
      logic lk, wok, rok;
      logic [31:0] d;
      logic [7:0] bd;
      s = c % SC; st = 5'(c); lk = st[2] ^ st[4];
      wok = !(st[0] && (st[2:1] == 2'b00 || st[2:1] == 2'b01));
      rok = !(st[0] && st[2:1] == 2'b01);
      cfg(s, st, lk);
      wa = s*32 + c;
      d = 32'hC0DE_0000 + c * 32'h0011_0101;
      blk_op(1'b1, wa, d, v, e, r32);
      check(v && e == !wok, "R3/R4 blk write err", {v, e}, {1'b1, !wok});
      if (wok) for (int k = 0; k < 4; k++) mdl[wa*4+k] = d[k*8 +: 8];
      blk_op(1'b0, wa, 32'h0, v, e, r32);
      check(v && e == !rok && r32 == (rok ? mword(wa) : 32'h0), "R1/R5 blk read",
            r32, rok ? mword(wa) : 32'h0);
      ba = s*128 + c*4 + (c % 4);
      bd = 8'(c*7 + 3);
      byt_op(1'b1, 1'b0, ba, bd, v, e, r8);
      check(v && e == lk, "R7 byte write lock", {v, e}, {1'b1, lk});
      if (!lk) mdl[ba] = bd;
      byt_op(1'b0, 1'b0, ba, 8'h0, v, e, r8);
      check(v && !e && r8 == mdl[ba], "R6 byte read", r8, mdl[ba]);
      byt_op(1'b0, 1'b0, s*128 + c*4 + ((c+2) % 4), 8'h0, v, e, r8);
      check(r8 == mdl[s*128 + c*4 + ((c+2) % 4)], "R4/R6 neighbour byte", r8, mdl[s*128 + c*4 + ((c+2) % 4)]);
    end

    // R8: select bit set reaches nothing
    byt_op(1'b1, 1'b1, 9, 8'hEE ^ mdl[9], v, e, r8);
    check(!v, "R8 no response", v, 0);
    byt_op(1'b0, 1'b0, 9, 8'h0, v, e, r8);
    check(r8 == mdl[9], "R8 memory untouched", r8, mdl[9]);

    // R9: collision
    cfg(0, 5'b0, 1'b0);
    @(negedge clk);
    blk_req_valid = 1'b1; blk_we = 1'b0; blk_addr = BAW'(3);
    byt_req_valid = 1'b1; byt_we = 1'b1; byt_e2 = 1'b0; byt_addr = YAW'(13); byt_wdata = 8'h77;
    #1 check(byt_req_ready == 0, "R9 byte stalled", byt_req_ready, 0);
    @(posedge clk); #1;
    check(blk_rsp_valid && !byt_rsp_valid && blk_rdata == mword(3), "R9 block served first", blk_rdata, mword(3));
    blk_req_valid = 1'b0;
    @(posedge clk); #1;
    check(byt_rsp_valid && !byt_err, "R9 byte served next", {byt_rsp_valid, byt_err}, 2'b10);
    byt_req_valid = 1'b0;
    mdl[13] = 8'h77;

    // R10: reset clears protection
    cfg(1, 5'b00011, 1'b1);
    blk_op(1'b1, 32, 32'h1, v, e, r32);
    check(e, "R10 protection active", e, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    blk_op(1'b1, 32, 32'hFEED_BEEF, v, e, r32);
    check(v && !e, "R10 open after reset", e, 0);
    for (int k = 0; k < 4; k++) mdl[128+k] = 8'(32'hFEED_BEEF >> (8*k));
    byt_op(1'b1, 1'b0, 130, 8'h42, v, e, r8);
    check(v && !e, "R10 unlocked after reset", e, 0);
    mdl[130] = 8'h42;

    // final full readback through the now-open block view
    for (int w = 0; w < SC*32; w++) begin
      blk_op(1'b0, w, 32'h0, v, e, r32);
      check(r32 == mword(w), "R4/R7 final array", r32, mword(w));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule